// File: doc/BRIEF.md
# Output Strobe Sequencer with Timed Gaps

This block sits between a word FIFO and a transmit link. It takes one queued trigger at a time. Each trigger carries a buffer number. The block waits until that buffer's delay-ready flag is high and the FIFO offers a word. It then moves the event's words onto the link, one data strobe per word, and stops after the end-of-event word. Other logic fills the FIFO and counts the delays. This block only decides when a word leaves and when the link stays idle.

Each FIFO word carries three flags beside its data. A gap word is not transmitted. Its low data bits give a gap value, and the link stays idle for a fixed base of clocks plus that value before the next word leaves. An empty-flagged word ends its event at once and produces no strobe. The trigger is used up with nothing sent. The stream must not put a gap before the second data word of an event.

The trigger input and the FIFO input follow valid/ready rules. A source raises valid and keeps it and its payload steady until the clock edge where ready is also high. That edge is the transfer. Ready never depends on valid. The link output has no back-pressure. A word is on the link in the one clock its strobe is high.

Top module: `osq_sequencer`

## Requirements
- R1: In reset and in the first cycle after it, tx_strobe is 0, trig_ready is 1 and fifo_ready is 0.
- R2: trig_ready is high only while no event is in progress. From the cycle after a trigger transfer until the event ends, no other trigger is taken.
- R3: After a trigger transfer, no FIFO word is taken and no strobe occurs until fifo_valid and buf_ready[trig_buf] are both high. The buf_ready bits of other buffers have no effect.
- R4: A data word (fifo_empty=0, fifo_gap=0) taken at a clock edge gives tx_strobe=1 with tx_data equal to its data in the following cycle, for exactly one clock. Words that are offered back to back give strobes in consecutive cycles.
- R5: A gap word (fifo_gap=1, fifo_empty=0) is never strobed. Its value is fifo_data[GAP_W-1:0]. When the next word is already offered, the strobes before and after the gap are separated by exactly GAP_BASE plus that value idle clocks (6 idle clocks for a value of 0).
- R6: A word with fifo_empty=1 is taken without a strobe. It ends the event, and trig_ready is high again in the next cycle. fifo_empty takes priority over fifo_gap and fifo_eoe.
- R7: A data word with fifo_eoe=1 is strobed like any data word and ends the event. trig_ready is high again from the cycle after it is taken.
- R8: While tx_strobe is low, tx_data keeps the last word that was strobed.
- R9: Once the first word of an event has been taken, buf_ready has no further effect on that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | A queued trigger is offered |
| trig_ready | output | 1 | Sequencer takes a trigger |
| trig_buf | input | BUF_W | Buffer number of the offered trigger |
| buf_ready | input | NBUF | Delay-ready flag per buffer |
| fifo_valid | input | 1 | FIFO head word is offered |
| fifo_ready | output | 1 | Sequencer takes the head word |
| fifo_data | input | DATA_W | Head word data, or gap value in the low GAP_W bits |
| fifo_gap | input | 1 | Head word is a gap word |
| fifo_empty | input | 1 | Head word marks an empty event |
| fifo_eoe | input | 1 | Head word is the last of its event |
| tx_strobe | output | 1 | One-clock strobe per transmitted word |
| tx_data | output | DATA_W | Transmitted word |

## Verification
The bench builds the block with its defaults: 23-bit data, 12-bit gap values, four buffers and a gap base of 6. It drives gap values 0 and 9. These show the base pause alone and a pause with an added value, each measured to the exact clock between strobes. Four buffers let one buffer be held not-ready while its neighbours are ready. The largest gap value, 4095, is covered only by the 13-bit counter's width and its bound assertion, not by a run.

// File: rtl/osq_pkg.sv
package osq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_GAP  = 2'd3
  } osq_state_e;
endpackage

// File: rtl/osq_trig_latch.sv
module osq_trig_latch #(
  parameter int NBUF  = 4,
  parameter int BUF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUF_W-1:0] buf_in,
  input  logic [NBUF-1:0]  flags,
  output logic             sel_ready
);
  logic [BUF_W-1:0] cur_buf;
  logic [NBUF-1:0]  hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_buf <= '0;
    else if (accept) cur_buf <= buf_in;
  end

  // One decoded term per buffer, ORed together
  for (genvar b = 0; b < NBUF; b++) begin : g_sel
    assign hit[b] = flags[b] && (cur_buf == BUF_W'(b));
  end
  assign sel_ready = |hit;
endmodule

// File: rtl/osq_gap_timer.sv
module osq_gap_timer #(
  parameter int GAP_W    = 12,
  parameter int GAP_BASE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] gap_val,
  output logic             done
);
  localparam int CNT_W = GAP_W + 1;
  // The cycle in which the gap word is taken and the cycle that leaves the
  // gap state both count toward the pause, so counting starts at 2.
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      limit <= '0;
    end else if (start) begin
      cnt   <= CNT_INIT;
      limit <= {1'b0, gap_val} + CNT_W'(GAP_BASE);
    end else if (cnt != limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == limit);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
  a_r5_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/osq_out_stage.sv
module osq_out_stage #(
  parameter int DATA_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              strobe,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      dout   <= '0;
    end else begin
      strobe <= load;
      if (load) dout <= din;
    end
  end

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));
endmodule

// File: rtl/osq_sequencer.sv
module osq_sequencer #(
  parameter int DATA_W   = 23,
  parameter int GAP_W    = 12,
  parameter int NBUF     = 4,
  parameter int GAP_BASE = 6,
  localparam int BUF_W   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [BUF_W-1:0]  trig_buf,
  input  logic [NBUF-1:0]   buf_ready,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_gap,
  input  logic              fifo_empty,
  input  logic              fifo_eoe,
  output logic              tx_strobe,
  output logic [DATA_W-1:0] tx_data
);
  import osq_pkg::*;

  osq_state_e state, state_n;
  logic sel_ready, gap_done;
  logic trig_take, take, take_empty, take_gap, take_data;
  logic [1:0] sent_cnt;

  assign trig_ready = (state == ST_IDLE);
  assign fifo_ready = (state == ST_SEND);
  assign trig_take  = trig_valid && trig_ready;
  assign take       = fifo_valid && fifo_ready;
  assign take_empty = take && fifo_empty;
  assign take_gap   = take && !fifo_empty && fifo_gap;
  assign take_data  = take && !fifo_empty && !fifo_gap;

  osq_trig_latch #(.NBUF(NBUF), .BUF_W(BUF_W)) i_trig (
    .clk(clk), .rst_n(rst_n), .accept(trig_take), .buf_in(trig_buf),
    .flags(buf_ready), .sel_ready(sel_ready));

  osq_gap_timer #(.GAP_W(GAP_W), .GAP_BASE(GAP_BASE)) i_gap (
    .clk(clk), .rst_n(rst_n), .start(take_gap),
    .gap_val(fifo_data[GAP_W-1:0]), .done(gap_done));

  osq_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_n), .load(take_data), .din(fifo_data),
    .strobe(tx_strobe), .dout(tx_data));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (trig_take) state_n = ST_WAIT;
      ST_WAIT: if (fifo_valid && sel_ready) state_n = ST_SEND;
      ST_SEND: begin
        if (take_empty)                  state_n = ST_IDLE;
        else if (take_gap)               state_n = ST_GAP;
        else if (take_data && fifo_eoe)  state_n = ST_IDLE;
      end
      ST_GAP:  if (gap_done) state_n = ST_SEND;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  // Data words sent in the current event, saturating at two
  always_ff @(posedge clk) begin
    if (!rst_n || trig_take)            sent_cnt <= '0;
    else if (take_data && sent_cnt != 2'd2) sent_cnt <= sent_cnt + 1'b1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    trig_take |=> !trig_ready);
  a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !sel_ready) |=> !fifo_ready);
  a_r4_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(take_data));
  a_r5_gap_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    take_gap |-> (sent_cnt == 2'd2));
  a_r5_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> !tx_strobe);
  a_r6_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    take_empty |=> (!tx_strobe && trig_ready));
endmodule

// File: tb/test_osq_sequencer.sv
module test_osq_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 23;
  localparam int NBUF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic trig_ready;
  logic [1:0] trig_buf = '0;
  logic [NBUF-1:0] buf_ready = '1;
  logic fifo_valid, fifo_ready, fifo_gap, fifo_empty, fifo_eoe;
  logic [DATA_W-1:0] fifo_data;
  logic tx_strobe;
  logic [DATA_W-1:0] tx_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [DATA_W-1:0] q_data [64];
  logic q_gap [64];
  logic q_empty [64];
  logic q_eoe [64];
  int wr = 0;
  int rd = 0;

  logic [DATA_W-1:0] st_data [64];
  int st_cyc [64];
  int nst = 0;
  int ncyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_valid = (rd < wr);
  assign fifo_data  = q_data[rd[5:0]];
  assign fifo_gap   = q_gap[rd[5:0]];
  assign fifo_empty = q_empty[rd[5:0]];
  assign fifo_eoe   = q_eoe[rd[5:0]];

  always @(posedge clk) if (fifo_valid && fifo_ready) rd <= rd + 1;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (tx_strobe && nst < 64) begin
      st_data[nst] = tx_data;
      st_cyc[nst] = ncyc;
      nst = nst + 1;
    end
  end

  osq_sequencer i_osq_sequencer (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_buf(trig_buf), .buf_ready(buf_ready), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .fifo_gap(fifo_gap),
    .fifo_empty(fifo_empty), .fifo_eoe(fifo_eoe), .tx_strobe(tx_strobe),
    .tx_data(tx_data));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int d, input bit g, input bit e, input bit eo);
    q_data[wr[5:0]] = DATA_W'(d);
    q_gap[wr[5:0]] = g;
    q_empty[wr[5:0]] = e;
    q_eoe[wr[5:0]] = eo;
    wr = wr + 1;
  endtask

  task automatic fire(input int b);
    @(negedge clk);
    trig_buf = 2'(b);
    trig_valid = 1'b1;
    while (!trig_ready) @(negedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    chk("R1 strobe in reset", tx_strobe, 0);
    chk("R1 trig_ready in reset", trig_ready, 1);
    chk("R1 fifo_ready in reset", fifo_ready, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 strobe after reset", tx_strobe, 0);
    chk("R1 trig_ready after reset", trig_ready, 1);
    chk("R1 fifo_ready after reset", fifo_ready, 0);
  endtask

  task automatic t_basic();
    int base = nst;
    push('h111, 0, 0, 0);
    push('h222, 0, 0, 0);
    push('h333, 0, 0, 1);
    fire(0);
    idle(10);
    chk("R4 strobe count", nst - base, 3);
    chk("R4 word0", int'(st_data[base]), 'h111);
    chk("R4 word1", int'(st_data[base+1]), 'h222);
    chk("R7 eoe word sent", int'(st_data[base+2]), 'h333);
    chk("R4 back to back", st_cyc[base+2] - st_cyc[base], 2);
    chk("R7 idle after eoe", trig_ready, 1);
    chk("R8 strobe low", tx_strobe, 0);
    chk("R8 data held", int'(tx_data), 'h333);
  endtask

  task automatic t_gap(input int g);
    int base = nst;
    push('h1A0, 0, 0, 0);
    push('h1A1, 0, 0, 0);
    push('h7F000 | g, 1, 0, 0);
    push('h1A2, 0, 0, 0);
    push('h1A3, 0, 0, 1);
    fire(1);
    idle(g + 25);
    chk("R5 strobe count", nst - base, 4);
    chk("R5 word after gap", int'(st_data[base+2]), 'h1A2);
    chk("R5 last word", int'(st_data[base+3]), 'h1A3);
    chk("R5 gap spacing", st_cyc[base+2] - st_cyc[base+1], g + 7);
    chk("R5 after gap back to back", st_cyc[base+3] - st_cyc[base+2], 1);
  endtask

  task automatic t_empty();
    int base = nst;
    push('h555, 1, 1, 1);
    fire(1);
    idle(8);
    chk("R6 no strobe", nst - base, 0);
    chk("R6 word consumed", rd, wr);
    chk("R6 trigger taken again", trig_ready, 1);
    chk("R8 data kept over empty", int'(tx_data), 'h1A3);
  endtask

  task automatic t_wait_flag();
    int base = nst;
    int rd0;
    buf_ready = 4'b1011;
    push('h0C1, 0, 0, 0);
    push('h0C2, 0, 0, 1);
    rd0 = rd;
    fire(2);
    idle(10);
    chk("R3 no strobe while not ready", nst - base, 0);
    chk("R3 no word taken", rd, rd0);
    chk("R2 busy with event", trig_ready, 0);
    buf_ready[2] = 1'b1;
    idle(8);
    chk("R3 sent once ready", nst - base, 2);
    chk("R2 free after event", trig_ready, 1);
  endtask

  task automatic t_wait_fifo();
    int base = nst;
    fire(3);
    idle(8);
    chk("R3 no strobe with fifo empty", nst - base, 0);
    push('h0D1, 0, 0, 0);
    push('h0D2, 0, 0, 1);
    idle(8);
    chk("R3 sent once fifo valid", nst - base, 2);
    chk("R3 data order", int'(st_data[base+1]), 'h0D2);
  endtask

  task automatic t_drop();
    int base = nst;
    push('h0E1, 0, 0, 0);
    push('h0E2, 0, 0, 0);
    push('h0E3, 0, 0, 0);
    push('h0E4, 0, 0, 1);
    fire(0);
    while (nst == base) @(negedge clk);
    buf_ready = '0;
    idle(10);
    chk("R9 all words sent", nst - base, 4);
    chk("R9 last word", int'(st_data[base+3]), 'h0E4);
    buf_ready = '1;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gap(0);
    t_gap(9);
    t_empty();
    t_wait_flag();
    t_wait_fifo();
    t_drop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule